// File: doc/BRIEF.md
# Adaptive Delta Modulation Codec

This block is a cycle-level digital model of an adaptive delta-modulation codec. It has two paths.

The encoder path compares a signed input sample with the integrator of its own local decoder. On each enabled cycle it emits one bit. The bit is 1 when the sample is above the integrator and 0 otherwise. The same bit steps the local decoder, so the integrator tracks the input.

The decoder path takes one received bit per enabled cycle and rebuilds the same integrator waveform. Both paths share one decoder core.

In the decoder core, a four-bit history of received bits feeds a run detector. When the four most recent bits, including the one being accepted, are all equal, the step size follows a fast exponential attack toward its ceiling. Otherwise it follows a slower exponential decay toward its floor. The integrator adds or subtracts the present step according to the accepted bit, and it saturates at the signed limits instead of wrapping.

All state moves only on cycles with the clock enable high. Every output is registered and reflects the bit accepted at the previous enabled edge.

Top module: `adm_codec`

## Requirements
- R1: After reset, both integrators read 0, both steps read STEP_MIN (16), the encoder bit reads 0, and the bit history holds alternating bits with a 1 as the newest. Starting from reset, three equal 1 bits are therefore needed before the step starts to attack.
- R2: On a cycle with the clock enable low, no output changes, whatever the sample and received bit are.
- R3: On an enabled cycle the integrator becomes its old value plus the old step when the accepted bit is 1, and minus the old step when it is 0.
- R4: When the accepted bit and the three bits before it are all equal, the step becomes step + ((STEP_MAX - step) >> ATK_SHIFT), with ATK_SHIFT = 2. If that increment is 0, the step becomes STEP_MAX (3200).
- R5: Otherwise the step becomes step - ((step - STEP_MIN) >> DCY_SHIFT), with DCY_SHIFT = 4. If that decrement is 0, the step becomes STEP_MIN. The decay is therefore several times slower than the attack.
- R6: The step never leaves [STEP_MIN, STEP_MAX], a ratio of 200.
- R7: The integrator saturates at +32767 and -32768 and never wraps.
- R8: On an enabled cycle the encoder bit becomes 1 when the signed sample is strictly greater than the encoder integrator, and 0 otherwise. The same bit is the one the encoder's local decoder accepts in that cycle.
- R9: The decoder path follows only the received bit and is independent of the encoder path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_i | input | 1 | Clock enable; state advances only when high |
| sample_i | input | 16 | Signed sample to encode |
| enc_bit_o | output | 1 | Encoded bit, registered |
| enc_integ_o | output | 16 | Encoder local integrator, signed |
| enc_step_o | output | 16 | Encoder local step size |
| rx_bit_i | input | 1 | Received bit for the decoder path |
| dec_integ_o | output | 16 | Decoder integrator, signed |
| dec_step_o | output | 16 | Decoder step size |

## Verification
A wrong history or run decision does not show in the integrator until the next enabled cycle, because the integrator uses the step already held. The step output shows it one enabled cycle after the offending bit, as a move in the wrong direction. A faulty saturation or a faulty encoder comparison shows on the integrator or the encoder bit at the first edge after the fault.

These errors compound. A single wrong step value bends the integrator trajectory from then on, so comparing every output on every enabled cycle exposes a fault within one cycle of its cause.

// File: rtl/adm_pkg.sv
package adm_pkg;
  typedef enum logic {
    ADAPT_DECAY  = 1'b0,
    ADAPT_ATTACK = 1'b1
  } adapt_e;

  function automatic logic [7:0] alt_pattern(input int len);
    logic [7:0] p;
    for (int i = 0; i < 8; i++) p[i] = (i % 2 == 0) && (i < len);
    return p;
  endfunction
endpackage

// File: rtl/adm_run_detect.sv
module adm_run_detect #(
  parameter int HIST_LEN = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ce_i,
  input  logic           bit_i,
  output adm_pkg::adapt_e mode_o
);
  localparam logic [7:0]          ALT    = adm_pkg::alt_pattern(HIST_LEN);
  localparam logic [HIST_LEN-1:0] HRESET = ALT[HIST_LEN-1:0];

  logic [HIST_LEN-1:0] hist_q;
  logic [HIST_LEN-1:0] hist_d;
  logic [HIST_LEN-1:0] window;

  always_comb begin
    window = {hist_q[HIST_LEN-2:0], bit_i};
    hist_d = ce_i ? window : hist_q;
    mode_o = ((&window) || (~|window)) ? adm_pkg::ADAPT_ATTACK : adm_pkg::ADAPT_DECAY;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= HRESET;
    else        hist_q <= hist_d;
  end

  p_hist_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_i |=> $stable(hist_q));
endmodule

// File: rtl/adm_step_adapt.sv
module adm_step_adapt #(
  parameter int STEP_W    = 16,
  parameter int STEP_MIN  = 16,
  parameter int STEP_MAX  = 3200,
  parameter int ATK_SHIFT = 2,
  parameter int DCY_SHIFT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_i,
  input  adm_pkg::adapt_e   mode_i,
  output logic [STEP_W-1:0] step_o
);
  localparam logic [STEP_W-1:0] SMIN = STEP_W'(STEP_MIN);
  localparam logic [STEP_W-1:0] SMAX = STEP_W'(STEP_MAX);

  logic [STEP_W-1:0] step_q, step_d, inc, dec;

  always_comb begin
    inc    = (SMAX - step_q) >> ATK_SHIFT;
    dec    = (step_q - SMIN) >> DCY_SHIFT;
    step_d = step_q;
    if (ce_i) begin
      if (mode_i == adm_pkg::ADAPT_ATTACK)
        step_d = (inc == '0) ? SMAX : step_q + inc;
      else
        step_d = (dec == '0) ? SMIN : step_q - dec;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) step_q <= SMIN;
    else        step_q <= step_d;
  end

  assign step_o = step_q;

  p_step_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (step_q >= SMIN) && (step_q <= SMAX));
  p_step_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_i |=> $stable(step_q));
  p_attack_up_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_i && mode_i == adm_pkg::ADAPT_ATTACK) |=> step_q >= $past(step_q));
  p_decay_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_i && mode_i == adm_pkg::ADAPT_DECAY) |=> step_q <= $past(step_q));
endmodule

// File: rtl/adm_integrator.sv
module adm_integrator #(
  parameter int INT_W  = 16,
  parameter int STEP_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ce_i,
  input  logic                    bit_i,
  input  logic [STEP_W-1:0]       step_i,
  output logic signed [INT_W-1:0] integ_o
);
  localparam int EW = INT_W + 2;
  localparam logic signed [EW-1:0] POS_LIM = {3'b000, {(INT_W-1){1'b1}}};
  localparam logic signed [EW-1:0] NEG_LIM = {3'b111, {(INT_W-1){1'b0}}};

  logic signed [INT_W-1:0] integ_q, integ_d;
  logic signed [EW-1:0]    wide, stepx;

  always_comb begin
    stepx   = signed'(EW'(step_i));
    wide    = bit_i ? (EW'(integ_q) + stepx) : (EW'(integ_q) - stepx);
    integ_d = integ_q;
    if (ce_i) begin
      if (wide > POS_LIM)      integ_d = POS_LIM[INT_W-1:0];
      else if (wide < NEG_LIM) integ_d = NEG_LIM[INT_W-1:0];
      else                     integ_d = wide[INT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) integ_q <= '0;
    else        integ_q <= integ_d;
  end

  assign integ_o = integ_q;

  p_no_wrap_up_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_i && bit_i) |=> integ_q >= $past(integ_q));
  p_no_wrap_dn_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_i && !bit_i) |=> integ_q <= $past(integ_q));
  p_integ_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_i |=> $stable(integ_q));
endmodule

// File: rtl/adm_decoder.sv
module adm_decoder #(
  parameter int INT_W     = 16,
  parameter int STEP_W    = 16,
  parameter int HIST_LEN  = 4,
  parameter int STEP_MIN  = 16,
  parameter int STEP_MAX  = 3200,
  parameter int ATK_SHIFT = 2,
  parameter int DCY_SHIFT = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ce_i,
  input  logic                    bit_i,
  output logic signed [INT_W-1:0] integ_o,
  output logic [STEP_W-1:0]       step_o
);
  adm_pkg::adapt_e mode;

  adm_run_detect #(.HIST_LEN(HIST_LEN)) i_run (
    .clk(clk), .rst_n(rst_n), .ce_i(ce_i), .bit_i(bit_i), .mode_o(mode));

  adm_step_adapt #(
    .STEP_W(STEP_W), .STEP_MIN(STEP_MIN), .STEP_MAX(STEP_MAX),
    .ATK_SHIFT(ATK_SHIFT), .DCY_SHIFT(DCY_SHIFT)
  ) i_step (
    .clk(clk), .rst_n(rst_n), .ce_i(ce_i), .mode_i(mode), .step_o(step_o));

  adm_integrator #(.INT_W(INT_W), .STEP_W(STEP_W)) i_integ (
    .clk(clk), .rst_n(rst_n), .ce_i(ce_i), .bit_i(bit_i),
    .step_i(step_o), .integ_o(integ_o));
endmodule

// File: rtl/adm_codec.sv
module adm_codec #(
  parameter int INT_W     = 16,
  parameter int STEP_W    = 16,
  parameter int HIST_LEN  = 4,
  parameter int STEP_MIN  = 16,
  parameter int STEP_MAX  = 3200,
  parameter int ATK_SHIFT = 2,
  parameter int DCY_SHIFT = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ce_i,
  input  logic signed [INT_W-1:0] sample_i,
  output logic                    enc_bit_o,
  output logic signed [INT_W-1:0] enc_integ_o,
  output logic [STEP_W-1:0]       enc_step_o,
  input  logic                    rx_bit_i,
  output logic signed [INT_W-1:0] dec_integ_o,
  output logic [STEP_W-1:0]       dec_step_o
);
  logic enc_bit_d, enc_bit_q, cmp_bit;

  always_comb begin
    cmp_bit   = sample_i > enc_integ_o;
    enc_bit_d = ce_i ? cmp_bit : enc_bit_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) enc_bit_q <= 1'b0;
    else        enc_bit_q <= enc_bit_d;
  end

  assign enc_bit_o = enc_bit_q;

  adm_decoder #(
    .INT_W(INT_W), .STEP_W(STEP_W), .HIST_LEN(HIST_LEN), .STEP_MIN(STEP_MIN),
    .STEP_MAX(STEP_MAX), .ATK_SHIFT(ATK_SHIFT), .DCY_SHIFT(DCY_SHIFT)
  ) i_enc_dec (
    .clk(clk), .rst_n(rst_n), .ce_i(ce_i), .bit_i(cmp_bit),
    .integ_o(enc_integ_o), .step_o(enc_step_o));

  adm_decoder #(
    .INT_W(INT_W), .STEP_W(STEP_W), .HIST_LEN(HIST_LEN), .STEP_MIN(STEP_MIN),
    .STEP_MAX(STEP_MAX), .ATK_SHIFT(ATK_SHIFT), .DCY_SHIFT(DCY_SHIFT)
  ) i_rx_dec (
    .clk(clk), .rst_n(rst_n), .ce_i(ce_i), .bit_i(rx_bit_i),
    .integ_o(dec_integ_o), .step_o(dec_step_o));

  p_enc_cmp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ce_i |=> enc_bit_o == ($past(sample_i) > $past(enc_integ_o)));
  p_enc_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_i && cmp_bit) |=> enc_integ_o >= $past(enc_integ_o));
endmodule

// File: tb/test_adm_codec.sv
module test_adm_codec;
  localparam int SMIN = 16;
  localparam int SMAX = 3200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce = 1'b0;
  logic signed [15:0] sample = '0;
  logic rx_bit = 1'b0;
  logic enc_bit;
  logic signed [15:0] enc_integ, dec_integ;
  logic [15:0] enc_step, dec_step;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  adm_codec i_adm_codec (
    .clk(clk), .rst_n(rst_n), .ce_i(ce), .sample_i(sample),
    .enc_bit_o(enc_bit), .enc_integ_o(enc_integ), .enc_step_o(enc_step),
    .rx_bit_i(rx_bit), .dec_integ_o(dec_integ), .dec_step_o(dec_step));

  typedef struct {
    logic [3:0] h;
    int step;
    int integ;
  } ch_t;

  typedef struct {
    string tag;
    logic  ebit;
    int    eint, estep, dint, dstep;
  } exp_t;

  exp_t q[$];
  ch_t  m_enc, m_dec;
  logic m_ebit;

  // Reference behaviour taken from R3, R4, R5 and R7.
  function automatic ch_t adv(ch_t c, logic b);
    ch_t n;
    logic [3:0] w;
    int d;
    w = {c.h[2:0], b};
    n.h = w;
    if (w == 4'h0 || w == 4'hf) begin
      d = (SMAX - c.step) >>> 2;
      n.step = (d == 0) ? SMAX : c.step + d;
    end else begin
      d = (c.step - SMIN) >>> 4;
      n.step = (d == 0) ? SMIN : c.step - d;
    end
    n.integ = b ? c.integ + c.step : c.integ - c.step;
    if (n.integ > 32767) n.integ = 32767;
    if (n.integ < -32768) n.integ = -32768;
    return n;
  endfunction

  task automatic check(string tag, logic ab, int ai, int as, int di, int ds,
                       logic xb, int xi, int xs, int yi, int ys);
    n_chk++;
    if (ab !== xb || ai != xi || as != xs || di != yi || ds != ys) begin
      n_fail++;
      $display("FAIL %s: actual bit=%0b ei=%0d es=%0d di=%0d ds=%0d expected bit=%0b ei=%0d es=%0d di=%0d ds=%0d",
               tag, ab, ai, as, di, ds, xb, xi, xs, yi, ys);
    end
  endtask

  task automatic drive(logic c, int s, logic b, string tag);
    exp_t e;
    logic eb;
    @(negedge clk);
    ce = c;
    sample = 16'(s);
    rx_bit = b;
    if (c) begin
      eb = (s > m_enc.integ);
      m_ebit = eb;
      m_enc = adv(m_enc, eb);
      m_dec = adv(m_dec, b);
    end
    e.tag = tag;
    e.ebit = m_ebit;
    e.eint = m_enc.integ;
    e.estep = m_enc.step;
    e.dint = m_dec.integ;
    e.dstep = m_dec.step;
    q.push_back(e);
  endtask

  // Monitor: compares each queued expectation just after the edge it belongs to.
  always @(posedge clk) begin
    exp_t e;
    #2;
    if (q.size() > 0) begin
      e = q.pop_front();
      check(e.tag, enc_bit, int'(enc_integ), int'(enc_step), int'(dec_integ), int'(dec_step),
            e.ebit, e.eint, e.estep, e.dint, e.dstep);
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    m_enc.h = 4'b0101; m_enc.step = SMIN; m_enc.integ = 0;
    m_dec = m_enc;
    m_ebit = 1'b0;
    #35;
    // R1 reset state
    check("R1 reset", enc_bit, int'(enc_integ), int'(enc_step), int'(dec_integ), int'(dec_step),
          1'b0, 0, SMIN, 0, SMIN);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 history: alternating reset, three ones reach a four-long run
    for (int i = 0; i < 4; i++) drive(1'b1, 0, 1'b1, "R1 reset history run");
    // R4 attack up to ceiling, R7 positive saturation on decoder path
    for (int i = 0; i < 40; i++) drive(1'b1, 0, 1'b1, "R4 R7 attack and saturate up");
    // R5 decay toward floor with alternating bits
    for (int i = 0; i < 120; i++) drive(1'b1, 0, logic'(i % 2), "R5 decay alternating");
    // R2 enable low holds everything
    for (int i = 0; i < 6; i++) drive(1'b0, 30000, 1'b1, "R2 enable low hold");
    // R7 negative saturation and R3 stepping
    for (int i = 0; i < 60; i++) drive(1'b1, -32768, 1'b0, "R3 R7 zeros saturate down");
    // R9 decoder 00001111 pattern, R8 encoder tracking positive target
    for (int i = 0; i < 96; i++) drive(1'b1, 20000, logic'((i / 4) % 2), "R8 R9 track and pattern");
    // R6 bounds under mixed runs, R8 ramp input
    for (int i = 0; i < 150; i++) drive(1'b1, (i * 400) - 30000, logic'((i / 6) % 2), "R6 R8 ramp mixed");
    // R2 interleaved enable
    for (int i = 0; i < 20; i++) drive(logic'(i % 3 != 0), -5000, logic'(i % 2), "R2 R3 gapped enable");
    @(negedge clk);
    ce = 1'b0;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule